// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block sits on the target side of a bus interface and serves reads that external masters make of local data. The first read of an item is answered with a retry. In the same step the block starts a fetch of that item over the internal interconnect. The fetched word is held until the master repeats the read with the same address, and that repeat completes with the data. A read of any other address is told to retry while an item is outstanding or held. Such a read does not disturb the pending item.

A 15-bit discard timer starts on the retry that opens a transaction. If the master has not come back after 32768 clocks, the held word is thrown away and the block returns to idle without any help. A one-cycle timeout strobe is sent to the status logic, and a sticky timer-expired bit is set. Software clears that bit by writing a one to it. The timeout is advisory only: it points at a master that does not behave, and nothing has to be repaired. Bus signal sequencing and prefetch of more than one item are handled elsewhere.

Top module: `delayed_read_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, rsp_valid, fch_req, tmo_evt and sts_tte are all 0.
- R2: Each cycle with rd_req high produces exactly one cycle of rsp_valid on the next cycle, and rsp_valid is never high otherwise. A read seen while idle is answered with rsp_retry=1, and on the same cycle fch_req rises with fch_addr equal to the read address.
- R3: fch_req stays high with fch_addr unchanged until a cycle with fch_ack high. On that edge, fch_data is captured and fch_req drops on the next cycle.
- R4: A read that arrives while the fetch is outstanding is answered with retry, whatever its address. This includes a read on the same cycle as fch_ack. It starts no new fetch and does not restart the timer.
- R5: With data held, a read whose address equals the held address completes: rsp_retry=0 and rsp_data is the fetched word. The block then returns to idle, so the next read of that address is a fresh first read.
- R6: With data held, a read of a different address is answered with retry, starts no fetch, and leaves the held item intact.
- R7: If no completing read arrives, the held word is discarded exactly 32768 clock edges after the edge that sampled the opening read. tmo_evt is high for one cycle following that edge, and a later read of the same address is treated as a first read.
- R8: A matching read sampled on the expiry edge completes with the data, and no tmo_evt is produced.
- R9: sts_tte is set on the cycle tmo_evt is high and stays set until sts_clr is high. When the set and the clear fall on the same edge, the set wins.
- R10: If the timer expires before the fetch is acknowledged, tmo_evt still pulses. fch_req then stays high until fch_ack, reads meanwhile are retried without a new fetch, and the returned word is dropped as the block goes idle.
- R11: Every retry response carries rsp_data equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | One read attempt by an external master in this cycle |
| rd_addr | input | ADDR_W | Address of the read attempt |
| rsp_valid | output | 1 | A response to the previous cycle's read is present |
| rsp_retry | output | 1 | 1 = tell master to retry, 0 = complete |
| rsp_data | output | DATA_W | Read data on completion, 0 on retry |
| fch_req | output | 1 | Internal fetch request, held until acknowledged |
| fch_addr | output | ADDR_W | Address being fetched |
| fch_ack | input | 1 | Internal side returns the fetched word |
| fch_data | input | DATA_W | Fetched word, valid with fch_ack |
| sts_clr | input | 1 | Write-one-to-clear strobe for the timer-expired bit |
| tmo_evt | output | 1 | One-cycle strobe when held data is discarded |
| sts_tte | output | 1 | Sticky timer-expired status bit |

## Verification
The expiry of the discard timer can fall on the same edge as the matching repeat read. The bench walks the timer exactly to its terminal count and presents the repeat read at that edge. It then expects a completion carrying the fetched word and no timeout strobe. A companion run that leaves out the repeat read expects the strobe on that edge and not one cycle earlier. The status write-one-to-clear is also driven on an expiry edge, and the bit must read as set.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_FETCH = 2'd1,
    DR_HOLD  = 2'd2,
    DR_DRAIN = 2'd3
  } dr_state_e;
endpackage

// File: rtl/dr_timer.sv
module dr_timer #(
  parameter int TMR_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic at_tc
);
  localparam logic [TMR_W-1:0] TC = {TMR_W{1'b1}};

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && cnt_q != TC) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_tc = (cnt_q == TC);
endmodule

// File: rtl/dr_hold.sv
module dr_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              load_data,
  input  logic [DATA_W-1:0] new_data,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (load_addr) addr_q <= new_addr;
      if (load_data) data_q <= new_data;
    end
  end

  assign hit = (addr_q == cmp_addr);
endmodule

// File: rtl/dr_status.sv
module dr_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst)        bit_q <= 1'b0;
    else if (set_i) bit_q <= 1'b1;
    else if (clr_i) bit_q <= 1'b0;
  end
endmodule

// File: rtl/delayed_read_ctl.sv
module delayed_read_ctl
  import dr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fch_req,
  output logic [ADDR_W-1:0] fch_addr,
  input  logic              fch_ack,
  input  logic [DATA_W-1:0] fch_data,
  input  logic              sts_clr,
  output logic              tmo_evt,
  output logic              sts_tte
);
  dr_state_e state_q, state_d;

  logic              hit, at_tc;
  logic [DATA_W-1:0] held_data;
  logic              busy, first_rd, complete, expire, acked;

  assign busy     = (state_q == DR_FETCH) || (state_q == DR_HOLD);
  assign first_rd = (state_q == DR_IDLE) && rd_req;
  assign complete = (state_q == DR_HOLD) && rd_req && hit;
  assign expire   = busy && at_tc && !complete;
  assign acked    = fch_req && fch_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      DR_IDLE:  if (first_rd) state_d = DR_FETCH;
      DR_FETCH: begin
        if (expire)     state_d = acked ? DR_IDLE : DR_DRAIN;
        else if (acked) state_d = DR_HOLD;
      end
      DR_HOLD:  if (complete || expire) state_d = DR_IDLE;
      DR_DRAIN: if (acked) state_d = DR_IDLE;
      default:  state_d = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= DR_IDLE;
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_data  <= '0;
      fch_req   <= 1'b0;
      tmo_evt   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rd_req;
      rsp_retry <= rd_req && !complete;
      rsp_data  <= complete ? held_data : '0;
      tmo_evt   <= expire;
      if (first_rd)   fch_req <= 1'b1;
      else if (acked) fch_req <= 1'b0;
    end
  end

  dr_timer #(.TMR_W(TMR_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (first_rd),
    .run   (busy),
    .at_tc (at_tc)
  );

  dr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load_addr (first_rd),
    .new_addr  (rd_addr),
    .load_data (acked),
    .new_data  (fch_data),
    .cmp_addr  (rd_addr),
    .addr_q    (fch_addr),
    .data_q    (held_data),
    .hit       (hit)
  );

  dr_status u_status (
    .clk   (clk),
    .rst   (rst),
    .set_i (expire),
    .clr_i (sts_clr),
    .bit_q (sts_tte)
  );
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              fch_ack,
  input logic              sts_clr,
  input logic              rsp_valid,
  input logic              rsp_retry,
  input logic [DATA_W-1:0] rsp_data,
  input logic              fch_req,
  input logic [ADDR_W-1:0] fch_addr,
  input logic              tmo_evt,
  input logic              sts_tte
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) rd_req |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst) !rd_req |=> !rsp_valid); // R2
  AST_FETCH_WITH_RETRY: assert property (@(posedge clk) disable iff (rst) $rose(fch_req) |-> (rsp_valid && rsp_retry)); // R2
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (rst) (fch_req && !fch_ack) |=> (fch_req && $stable(fch_addr))); // R3
  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (rst) tmo_evt |=> !tmo_evt); // R7
  AST_COMPLETE_NO_TMO: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_retry) |-> !tmo_evt); // R8
  AST_TMO_SETS_STS: assert property (@(posedge clk) disable iff (rst) tmo_evt |-> sts_tte); // R9
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst) (sts_tte && !sts_clr) |=> sts_tte); // R9
  AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_retry) |-> (rsp_data == '0)); // R11
endmodule

bind delayed_read_ctl dr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req    (rd_req),
  .fch_ack   (fch_ack),
  .sts_clr   (sts_clr),
  .rsp_valid (rsp_valid),
  .rsp_retry (rsp_retry),
  .rsp_data  (rsp_data),
  .fch_req   (fch_req),
  .fch_addr  (fch_addr),
  .tmo_evt   (tmo_evt),
  .sts_tte   (sts_tte)
);

// File: tb/sim_delayed_read_ctl.sv
`timescale 1ns/1ps
module sim_delayed_read_ctl;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NROW = 13;
  localparam int HOLD_STEPS = 32766;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          fch_ack = 1'b0;
  logic [DW-1:0] fch_data = '0;
  logic          sts_clr = 1'b0;
  logic          rsp_valid, rsp_retry, fch_req, tmo_evt, sts_tte;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] fch_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  delayed_read_ctl #(.ADDR_W(AW), .DATA_W(DW), .TMR_W(15)) u0 (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_data(rsp_data),
    .fch_req(fch_req), .fch_addr(fch_addr), .fch_ack(fch_ack),
    .fch_data(fch_data), .sts_clr(sts_clr), .tmo_evt(tmo_evt), .sts_tte(sts_tte)
  );

  typedef struct packed {
    logic          rd;
    logic [31:0]   addr;
    logic          ack;
    logic [31:0]   data;
    logic          e_val;
    logic          e_rty;
    logic [31:0]   e_data;
    logic          e_fch;
    logic [31:0]   e_faddr;
    logic [7:0]    req;
  } vec_t;

  localparam vec_t VEC [NROW] = '{
    '{1'b1, 32'h100, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 32'h100, 8'd2}, // R2 first read
    '{1'b1, 32'h100, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 32'h100, 8'd4}, // R4 repeat early
    '{1'b1, 32'h200, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 32'h100, 8'd4}, // R4 other addr
    '{1'b0, 32'h0,   1'b1, 32'hCAFE0001, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   8'd3}, // R3 ack
    '{1'b1, 32'h200, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 32'h0,   8'd6}, // R6 mismatch
    '{1'b1, 32'h100, 1'b0, 32'h0,        1'b1, 1'b0, 32'hCAFE0001, 1'b0, 32'h0,   8'd5}, // R5 complete
    '{1'b0, 32'h0,   1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   8'd2}, // R2 quiet
    '{1'b1, 32'h100, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 32'h100, 8'd5}, // R5 fresh read
    '{1'b1, 32'h100, 1'b1, 32'hBEEF0002, 1'b1, 1'b1, 32'h0,        1'b0, 32'h0,   8'd4}, // R4 read with ack
    '{1'b1, 32'h100, 1'b0, 32'h0,        1'b1, 1'b0, 32'hBEEF0002, 1'b0, 32'h0,   8'd5}, // R5
    '{1'b1, 32'h300, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 32'h300, 8'd11}, // R11 retry data 0
    '{1'b0, 32'h0,   1'b1, 32'h12345678, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   8'd3}, // R3
    '{1'b1, 32'h300, 1'b0, 32'h0,        1'b1, 1'b0, 32'h12345678, 1'b0, 32'h0,   8'd5}  // R5
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    rd_req = 1'b1; rd_addr = a;
    step();
    rd_req = 1'b0;
  endtask

  task automatic do_ack(input logic [DW-1:0] d);
    fch_ack = 1'b1; fch_data = d;
    step();
    fch_ack = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
    report();
  end

  initial begin
    step(); step();
    check({rsp_valid, fch_req, tmo_evt, sts_tte} == 4'b0, "R1 in reset", {rsp_valid, fch_req, tmo_evt, sts_tte}, 0);
    rst = 1'b0;
    step();
    check({rsp_valid, fch_req, tmo_evt, sts_tte} == 4'b0, "R1 after reset", {rsp_valid, fch_req, tmo_evt, sts_tte}, 0);

    for (int i = 0; i < NROW; i++) begin
      vec_t v;
      logic ok;
      v = VEC[i];
      rd_req = v.rd; rd_addr = v.addr; fch_ack = v.ack; fch_data = v.data;
      step();
      rd_req = 1'b0; fch_ack = 1'b0;
      ok = (rsp_valid == v.e_val) && (rsp_retry == v.e_rty) && (rsp_data == v.e_data) &&
           (fch_req == v.e_fch) && (!v.e_fch || fch_addr == v.e_faddr);
      check(ok, $sformatf("R%0d row %0d", v.req, i),
            {rsp_valid, rsp_retry, fch_req, rsp_data, fch_addr},
            {v.e_val, v.e_rty, v.e_fch, v.e_data, v.e_fch ? v.e_faddr : fch_addr});
    end

    // R7: expiry exactly 32768 edges after the opening read, no return
    do_read(32'h400);
    check(rsp_retry && fch_req && fch_addr == 32'h400, "R2 open read", {rsp_retry, fch_req}, 2'b11);
    do_ack(32'hA5A5A5A5);
    repeat (HOLD_STEPS) step();
    check(tmo_evt == 1'b0, "R7 not before terminal", tmo_evt, 0);
    step();
    check(tmo_evt == 1'b1, "R7 expiry strobe", tmo_evt, 1);
    check(sts_tte == 1'b1, "R9 bit set", sts_tte, 1);
    step();
    check(tmo_evt == 1'b0, "R7 single pulse", tmo_evt, 0);
    check(sts_tte == 1'b1, "R9 sticky", sts_tte, 1);
    sts_clr = 1'b1; step(); sts_clr = 1'b0;
    check(sts_tte == 1'b0, "R9 write one clears", sts_tte, 0);
    do_read(32'h400);
    check(rsp_retry && fch_req && rsp_data == 0, "R7 data discarded, fresh fetch",
          {rsp_retry, fch_req, rsp_data}, {1'b1, 1'b1, 32'h0});

    // R8: matching read on the expiry edge completes
    do_ack(32'h5A5A5A5A);
    repeat (HOLD_STEPS) step();
    do_read(32'h400);
    check(rsp_valid && !rsp_retry && rsp_data == 32'h5A5A5A5A && !tmo_evt, "R8 complete on expiry edge",
          {rsp_retry, tmo_evt, rsp_data}, {1'b0, 1'b0, 32'h5A5A5A5A});
    step();
    check(tmo_evt == 1'b0 && sts_tte == 1'b0, "R8 no late timeout", {tmo_evt, sts_tte}, 0);

    // R10: expiry while fetch still outstanding; R9 set wins over clear
    do_read(32'h500);
    repeat (HOLD_STEPS + 1) step();
    sts_clr = 1'b1; step(); sts_clr = 1'b0;
    check(tmo_evt == 1'b1 && fch_req == 1'b1, "R10 expiry during fetch", {tmo_evt, fch_req}, 2'b11);
    check(sts_tte == 1'b1, "R9 set beats clear", sts_tte, 1);
    do_read(32'h500);
    check(rsp_retry && fch_req && fch_addr == 32'h500, "R10 read retried while draining",
          {rsp_retry, fch_req, fch_addr}, {1'b1, 1'b1, 32'h500});
    do_ack(32'hDEADBEEF);
    check(fch_req == 1'b0, "R10 drain acked", fch_req, 0);
    do_read(32'h500);
    check(rsp_retry && fch_req && rsp_data == 0, "R10 drained word dropped",
          {rsp_retry, fch_req, rsp_data}, {1'b1, 1'b1, 32'h0});
    do_ack(32'h1);
    step();
    report();
  end
endmodule